// File: doc/BRIEF.md
# Pipelined NTT Butterfly Unit

This block performs one Cooley-Tukey butterfly for a number-theoretic transform over the prime 7681. It serves transforms of 256 coefficients, including the negative-wrapped form used for multiplication modulo x^256 + 1. In each cycle it accepts an operand pair (a, b) and a twiddle factor w, all 13 bits wide. Four cycles later it returns a + w·b and a − w·b, both fully reduced modulo 7681. A valid flag travels through the pipeline with the data. A surrounding controller with two ping-pong memory banks can therefore read one pair and write one pair every cycle without stalling.

The modular multiplier computes the 26-bit product in the first stage. The product's upper thirteen bits are split into three small groups. Each group indexes a computed table that holds the group's weighted residue. The residues and the low product bits are folded together with carry-save adders, and a later stage removes up to three multiples of the modulus. The final add and subtract stage also uses carry-save rows. Each result and its modulus-corrected twin are formed side by side, and the sign of the corrected value picks one of them, so no carry chain runs ahead of a comparison.

Top module: `ntt_bfly_unit`

## Requirements
- R1: Whenever valid_in is high, a_in, b_in and w_in must each be below 7681.
- R2: sum_out equals (a + w·b) mod 7681 for the operands accepted together.
- R3: diff_out equals (a − w·b) mod 7681, taken as a non-negative residue.
- R4: Whenever valid_out is high, sum_out and diff_out both lie in [0, 7680].
- R5: Inputs sampled at rising edge N appear on sum_out, diff_out and valid_out after rising edge N+3, so the latency is four register stages.
- R6: Operands presented on consecutive cycles are all processed, at one butterfly per cycle with no stall.
- R7: A cycle with valid_in low gives a cycle with valid_out low four stages later, and neighbouring valid results are unaffected.
- R8: While rst is high at a rising edge, every stage's valid flag is cleared, so valid_out is low after that edge and stays low until new valid input has crossed the pipeline.
- R9: With w = 0, both outputs equal a.
- R10: Extreme operands (0 and 7680 in any combination) are reduced correctly, including the largest product 7680·7680.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands on a_in, b_in, w_in are valid this cycle |
| a_in | input | 13 | Upper butterfly operand |
| b_in | input | 13 | Lower butterfly operand, multiplied by the twiddle |
| w_in | input | 13 | Twiddle factor |
| valid_out | output | 1 | sum_out and diff_out hold a result |
| sum_out | output | 13 | (a + w·b) mod 7681 |
| diff_out | output | 13 | (a − w·b) mod 7681 |

## Verification
The range assertions assume that every operand presented with valid_in high is already reduced, below 7681. The carry-save sums and the selection among three multiples are correct only on that range. The bench therefore draws random operands modulo 7681 and applies the corner values 0 and 7680 directly, never anything larger. The latency and sum-plus-difference assertions compare outputs with the inputs of four edges earlier. They are enabled only once four edges have passed since reset, so they never look at inputs from before reset.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

    localparam int unsigned COEF_W = 13;
    localparam int unsigned Q      = 7681;
    localparam int unsigned PROD_W = 2 * COEF_W;
    localparam int unsigned RED_W  = COEF_W + 2;
    localparam int unsigned LAT    = 4;

    // upper product bits are cut into groups, each with its own residue table
    localparam int unsigned NGRP = 3;
    localparam int unsigned GRP_LO [NGRP] = '{13, 18, 22};
    localparam int unsigned GRP_W  [NGRP] = '{5, 4, 4};

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [RED_W-1:0]  red_t;
    typedef logic [PROD_W-1:0] prod_t;

    localparam red_t NEG_Q   = red_t'((1 << RED_W) - Q);
    localparam red_t Q_PLUS1 = red_t'(Q + 1);

    typedef struct packed {
        red_t s;
        red_t c;
    } csa_t;

    typedef struct packed {
        logic  v;
        coef_t a;
        prod_t p;
    } mul_st1_t;

    typedef struct packed {
        logic  v;
        coef_t a;
        csa_t  acc;
    } mul_st2_t;

    typedef struct packed {
        logic  v;
        coef_t a;
        coef_t t;
    } mul_st3_t;

    function automatic csa_t csa3(input red_t x, input red_t y, input red_t z);
        csa_t r;
        r.s = x ^ y ^ z;
        r.c = red_t'(((x & y) | (x & z) | (y & z)) << 1);
        return r;
    endfunction

endpackage

// File: rtl/ntt_modmul_lut.sv
module ntt_modmul_lut
    import ntt_bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_i,
    input  coef_t a_i,
    input  coef_t b_i,
    input  coef_t w_i,
    output logic  v_o,
    output coef_t a_o,
    output coef_t t_o
);

    mul_st1_t s1;
    mul_st2_t s2;
    mul_st3_t s3;

    // stage 1: raw product
    always_ff @(posedge clk) begin
        if (rst) begin
            s1.v <= 1'b0;
        end else begin
            s1.v <= v_i;
        end
        s1.a <= a_i;
        s1.p <= prod_t'(b_i) * prod_t'(w_i);
    end

    // stage 2: table residues of the upper groups, folded in carry-save form
    red_t res [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int unsigned LO = GRP_LO[g];
        localparam int unsigned GW = GRP_W[g];
        red_t tbl [2**GW];
        for (genvar e = 0; e < 2**GW; e++) begin : g_ent
            assign tbl[e] = red_t'((longint'(e) << LO) % longint'(Q));
        end
        assign res[g] = tbl[s1.p[LO +: GW]];
    end

    csa_t acc;
    always_comb begin
        acc.s = red_t'(s1.p[COEF_W-1:0]);
        acc.c = '0;
        for (int g = 0; g < NGRP; g++) begin
            acc = csa3(acc.s, acc.c, res[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2.v <= 1'b0;
        end else begin
            s2.v <= s1.v;
        end
        s2.a   <= s1.a;
        s2.acc <= acc;
    end

    // stage 3: resolve and strip up to three multiples of q in parallel
    red_t tot;
    logic signed [RED_W:0] d1, d2, d3;
    coef_t t_nx;

    always_comb begin
        tot = s2.acc.s + s2.acc.c;
        d1  = $signed({1'b0, tot}) - $signed((RED_W+1)'(Q));
        d2  = $signed({1'b0, tot}) - $signed((RED_W+1)'(2 * Q));
        d3  = $signed({1'b0, tot}) - $signed((RED_W+1)'(3 * Q));
        if (!d3[RED_W])      t_nx = coef_t'(d3);
        else if (!d2[RED_W]) t_nx = coef_t'(d2);
        else if (!d1[RED_W]) t_nx = coef_t'(d1);
        else                 t_nx = coef_t'(tot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s3.v <= 1'b0;
        end else begin
            s3.v <= s2.v;
        end
        s3.a <= s2.a;
        s3.t <= t_nx;
    end

    assign v_o = s3.v;
    assign a_o = s3.a;
    assign t_o = s3.t;

    // R10: folded residues never exceed what three subtractions can remove
    p_fold_bound_r10: assert property (@(posedge clk) disable iff (rst)
        s2.v |-> (red_t'(s2.acc.s + s2.acc.c) < red_t'(4 * Q)));

    // R4: the reduced product is a proper residue
    p_prod_range_r4: assert property (@(posedge clk) disable iff (rst)
        v_o |-> (t_o < coef_t'(Q)));

endmodule

// File: rtl/ntt_modaddsub.sv
module ntt_modaddsub
    import ntt_bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_i,
    input  coef_t a_i,
    input  coef_t t_i,
    output logic  v_o,
    output coef_t sum_o,
    output coef_t diff_o
);

    red_t ax, tx, ntx;
    csa_t add_c, sub_c, subw_c;
    red_t add_raw, add_red, sub_raw, sub_wrap;
    coef_t sum_nx, diff_nx;

    always_comb begin
        ax  = red_t'(a_i);
        tx  = red_t'(t_i);
        ntx = ~tx;
        // both candidates formed side by side, sign picks one
        add_raw  = ax + tx;
        add_c    = csa3(ax, tx, NEG_Q);
        add_red  = add_c.s + add_c.c;
        sub_c    = csa3(ax, ntx, red_t'(1));
        sub_raw  = sub_c.s + sub_c.c;
        subw_c   = csa3(ax, ntx, Q_PLUS1);
        sub_wrap = subw_c.s + subw_c.c;
        sum_nx   = add_red[RED_W-1] ? coef_t'(add_raw) : coef_t'(add_red);
        diff_nx  = sub_raw[RED_W-1] ? coef_t'(sub_wrap) : coef_t'(sub_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
        end else begin
            v_o <= v_i;
        end
        sum_o  <= sum_nx;
        diff_o <= diff_nx;
    end

    // R4: both butterfly outputs are proper residues
    p_sum_range_r4: assert property (@(posedge clk) disable iff (rst)
        v_o |-> (sum_o < coef_t'(Q)));

    // R3: the difference is non-negative and reduced
    p_diff_range_r3: assert property (@(posedge clk) disable iff (rst)
        v_o |-> (diff_o < coef_t'(Q)));

endmodule

// File: rtl/ntt_bfly_unit.sv
module ntt_bfly_unit
    import ntt_bfly_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [12:0]       a_in,
    input  logic [12:0]       b_in,
    input  logic [12:0]       w_in,
    output logic              valid_out,
    output logic [12:0]       sum_out,
    output logic [12:0]       diff_out
);

    logic  mv;
    coef_t ma, mt;

    ntt_modmul_lut u_mul (
        .clk (clk),
        .rst (rst),
        .v_i (valid_in),
        .a_i (a_in),
        .b_i (b_in),
        .w_i (w_in),
        .v_o (mv),
        .a_o (ma),
        .t_o (mt)
    );

    ntt_modaddsub u_as (
        .clk    (clk),
        .rst    (rst),
        .v_i    (mv),
        .a_i    (ma),
        .t_i    (mt),
        .v_o    (valid_out),
        .sum_o  (sum_out),
        .diff_o (diff_out)
    );

    // edges seen since reset, saturating, so history checks never reach before reset
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'(LAT)) since_rst <= since_rst + 3'd1;
    end

    // R1: operand contract
    p_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        valid_in |-> (a_in < 13'(Q) && b_in < 13'(Q) && w_in < 13'(Q)));

    // R5: valid travels exactly four stages
    p_valid_lat_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT)) |-> (valid_out == $past(valid_in, 4)));

    // R2: sum plus difference recovers twice the upper operand
    p_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'(LAT) && valid_out) |->
        (((32'(sum_out) + 32'(diff_out)) % Q) == ((32'($past(a_in, 4)) * 2) % Q)));

endmodule

// File: tb/ntt_bfly_unit_tb.sv
module ntt_bfly_unit_tb_top;

    localparam int QM = 7681;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [12:0] a_in, b_in, w_in;
    logic        valid_out;
    logic [12:0] sum_out, diff_out;

    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'h1234_5678;
    bit done = 0;

    always #5 clk = ~clk;

    ntt_bfly_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .a_in      (a_in),
        .b_in      (b_in),
        .w_in      (w_in),
        .valid_out (valid_out),
        .sum_out   (sum_out),
        .diff_out  (diff_out)
    );

    // expected results in flight, index 3 is due at the current falling edge
    bit    pv   [4];
    int    ps   [4];
    int    pd   [4];
    string ptag [4];

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic void model(input int a, input int b, input int w,
                                  output int s, output int d);
        longint p;
        p = (longint'(w) * longint'(b)) % QM;
        s = int'((longint'(a) + p) % QM);
        d = int'((longint'(a) - p + QM) % QM);
    endfunction

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % QM);
    endfunction

    // one cycle: check what is due, then present new operands
    task automatic push(input bit v, input int a, input int b, input int w,
                        input string tag);
        int s, d;
        @(negedge clk);
        if (pv[3]) begin
            chk({ptag[3], " R5 valid_out"}, int'(valid_out), 1);
            chk({ptag[3], " R2 sum"}, int'(sum_out), ps[3]);
            chk({ptag[3], " R3 diff"}, int'(diff_out), pd[3]);
            chk({ptag[3], " R4 range"}, int'(sum_out < 13'(QM) && diff_out < 13'(QM)), 1);
        end else begin
            chk("R7 idle slot valid_out", int'(valid_out), 0);
        end
        for (int i = 3; i > 0; i--) begin
            pv[i] = pv[i-1]; ps[i] = ps[i-1]; pd[i] = pd[i-1]; ptag[i] = ptag[i-1];
        end
        model(a, b, w, s, d);
        pv[0] = v; ps[0] = s; pd[0] = d; ptag[0] = tag;
        valid_in = v;
        a_in = 13'(a); b_in = 13'(b); w_in = 13'(w);
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) push(1'b0, 0, 0, 0, "idle");
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) pv[i] = 1'b0;
        rst = 1'b1; valid_in = 1'b1; a_in = '0; b_in = '0; w_in = '0;
        repeat (5) @(negedge clk);
        chk("R8 valid_out under reset", int'(valid_out), 0);
        valid_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        flush();
    endtask

    task automatic t_corners();
        int v [2] = '{0, QM - 1};
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++)
                for (int k = 0; k < 2; k++)
                    push(1'b1, v[i], v[j], v[k], "R10 corner");
        push(1'b1, 1, QM - 1, QM - 1, "R10 max product");
        flush();
    endtask

    task automatic t_zero_twiddle();
        push(1'b1, 1234, 5000, 0, "R9 w=0");
        push(1'b1, QM - 1, QM - 1, 0, "R9 w=0 top");
        push(1'b1, 0, 77, 0, "R9 w=0 zero");
        flush();
    endtask

    task automatic t_stream();
        for (int i = 0; i < 300; i++) push(1'b1, rnd(), rnd(), rnd(), "R6 stream");
        flush();
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 60; i++) push(((i % 3) != 1), rnd(), rnd(), rnd(), "R7 gapped");
        flush();
    endtask

    task automatic t_midreset();
        push(1'b1, 10, 20, 30, "R8 pre");
        push(1'b1, 11, 21, 31, "R8 pre");
        @(negedge clk);
        rst = 1'b1; valid_in = 1'b0;
        for (int i = 0; i < 4; i++) pv[i] = 1'b0;
        @(negedge clk);
        chk("R8 valid_out after reset edge", int'(valid_out), 0);
        rst = 1'b0;
        flush();
        push(1'b1, 100, 200, 300, "R8 post");
        flush();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin pv[i] = 1'b0; ptag[i] = ""; end
        t_reset();
        t_corners();
        t_zero_twiddle();
        t_stream();
        t_gaps();
        t_midreset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule